// File: doc/BRIEF.md
# Compressed Instruction Expander

This block turns a 16-bit compressed RISC-V instruction into the standard 32-bit encoding that does the same thing, so the rest of the decode path only has to handle one format. It is purely combinational. The input is a 32-bit fetch word. When its two low bits are `11`, the word is already a full-length instruction and goes out unchanged. Otherwise only the low 16 bits are decoded and the upper half is ignored.

Each compressed format spreads its immediate over the instruction in its own bit order, and the 3-bit short register fields stand for x8 to x15. The expander puts every immediate back together, sign-extends or zero-extends it as the format requires, and writes a legal 32-bit word using the base opcodes. The parameter `XLEN` (32 or 64) picks how the slots shared between the two widths are read. Reserved or invalid encodings raise `out_illegal`.

Top module: `rvc_expander`

## Requirements
- R1: A word with bits [1:0] = `11` appears on `out_word` unchanged, with `out_compressed` = 0 and `out_illegal` = 0. For any other low-bit value, `out_compressed` = 1 and bits [31:16] of the input have no effect.
- R2: Quadrant 00, funct3 000 (add scaled immediate to sp) expands to `addi x(8+c[4:2]), x2, imm`. The immediate is zero-extended and is `{c[10:7], c[12:11], c[5], c[6], 00}`.
- R3: Quadrant 00 loads and stores use base x(8+c[9:7]) and data register x/f(8+c[4:2]). Word forms have offset `{c[5], c[12:10], c[6], 00}` and doubleword forms `{c[6:5], c[12:10], 000}`. funct3 001/101 give fld/fsd and 010/110 give lw/sw. Slots 011/111 give ld/sd when XLEN=64 and flw/fsw when XLEN=32.
- R4: In quadrant 01 the 6-bit immediate `{c[12], c[6:2]}` is sign-extended. funct3 000 gives `addi rd,rd,imm` (the all-zero case is `addi x0,x0,0`) and 010 gives `addi rd,x0,imm`. funct3 001 gives `addiw rd,rd,imm` when XLEN=64.
- R5: Quadrant 01 funct3 101 gives `jal x0`, and funct3 001 gives `jal x1` when XLEN=32. The offset is sign-extended from `{c[12], c[8], c[10:9], c[6], c[7], c[2], c[11], c[5:3], 0}`, covering -2048 to +2046.
- R6: Quadrant 01 funct3 110/111 give `beq`/`bne` of x(8+c[9:7]) against x0. The offset is sign-extended from `{c[12], c[6:5], c[2], c[11:10], c[4:3], 0}`, covering -256 to +254.
- R7: Quadrant 01 funct3 011 with rd = 2 gives `addi x2,x2,imm`, where imm = sext `{c[12], c[4:3], c[5], c[2], c[6], 0000}` (-512 to +496). With any other rd it gives `lui rd`, whose upper immediate is sext `{c[12], c[6:2]}`.
- R8: Quadrant 01 funct3 100 with c[11:10] = 00/01/10 gives srli/srai/andi on x(8+c[9:7]), with shift amount `{c[12], c[6:2]}`. When XLEN=32, a shift with c[12] = 1 is illegal.
- R9: Quadrant 01 funct3 100 with c[11:10] = 11 gives a register operation on rd' and rs2' = x(8+c[4:2]). With c[12] = 0, c[6:5] = 00/01/10/11 selects sub/xor/or/and. With c[12] = 1, 00/01 select subw/addw; these exist only when XLEN=64.
- R10: Quadrant 10 funct3 000 gives `slli rd,rd,sh` (c[12] = 1 is illegal when XLEN=32). The sp-based forms use base x2: fldsp/fsdsp (001/101), lwsp/swsp (010/110), and slots 011/111 (ldsp/sdsp when XLEN=64, flwsp/fswsp when XLEN=32). Load offsets are `{c[3:2], c[12], c[6:4], 00}` for words and `{c[4:2], c[12], c[6:5], 000}` for doublewords. Store offsets are `{c[8:7], c[12:9], 00}` for words and `{c[9:7], c[12:10], 000}` for doublewords.
- R11: Quadrant 10 funct3 100 is decoded from c[12], rd = c[11:7] and rs2 = c[6:2]:
  - c[12] = 0, rs2 = 0: `jalr x0,rd,0`
  - c[12] = 0, rs2 ≠ 0: `add rd,x0,rs2`
  - c[12] = 1, rd = 0, rs2 = 0: `ebreak` (0x00100073)
  - c[12] = 1, rs2 = 0: `jalr x1,rd,0`
  - c[12] = 1, rs2 ≠ 0: `add rd,rd,rs2`
- R12: The following encodings raise `out_illegal`, and `out_word` is then the input's low 16 bits zero-extended:
  - the all-zero halfword
  - a zero immediate in the sp-scaled add, the sp adjust or lui
  - quadrant 00 funct3 100
  - li, addiw, lwsp or ldsp with rd = 0
  - the register jump (c[12] = 0) with rd = 0
  - quadrant 01 c[12] = 1 register operations other than subw/addw
  - 64-bit-only forms when XLEN=32

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| in_word | input | 32 | Fetched instruction word; a compressed instruction uses bits [15:0] |
| out_word | output | 32 | Equivalent 32-bit instruction, or the zero-extended halfword when illegal |
| out_illegal | output | 1 | Input is a reserved or invalid compressed encoding |
| out_compressed | output | 1 | Input was a 16-bit instruction (bits [1:0] not `11`) |

## Verification
The bench builds two copies of the expander side by side, one with XLEN=32 and one with XLEN=64, and drives the same word into both. This covers both meanings of every shared slot in one run: jal against addiw, flw/fsw against ld/sd, flwsp/fswsp against ldsp/sdsp, and the legality of shift amounts of 32 and above and of the word-sized register operations. Each immediate format is driven at its positive and negative extremes so that the sign-extension paths and every scrambled bit position are observed.

// File: rtl/rvc_pkg.sv
package rvc_pkg;

  localparam logic [6:0] OPC_LOAD     = 7'b0000011;
  localparam logic [6:0] OPC_LOAD_FP  = 7'b0000111;
  localparam logic [6:0] OPC_OP_IMM   = 7'b0010011;
  localparam logic [6:0] OPC_OP_IMM32 = 7'b0011011;
  localparam logic [6:0] OPC_STORE    = 7'b0100011;
  localparam logic [6:0] OPC_STORE_FP = 7'b0100111;
  localparam logic [6:0] OPC_OP       = 7'b0110011;
  localparam logic [6:0] OPC_LUI      = 7'b0110111;
  localparam logic [6:0] OPC_OP32     = 7'b0111011;
  localparam logic [6:0] OPC_BRANCH   = 7'b1100011;
  localparam logic [6:0] OPC_JALR     = 7'b1100111;
  localparam logic [6:0] OPC_JAL      = 7'b1101111;

  localparam logic [31:0] WORD_EBREAK = 32'h0010_0073;

  localparam logic [2:0] F3_ADD  = 3'b000;
  localparam logic [2:0] F3_SLL  = 3'b001;
  localparam logic [2:0] F3_WORD = 3'b010;
  localparam logic [2:0] F3_DBL  = 3'b011;
  localparam logic [2:0] F3_XOR  = 3'b100;
  localparam logic [2:0] F3_SR   = 3'b101;
  localparam logic [2:0] F3_OR   = 3'b110;
  localparam logic [2:0] F3_AND  = 3'b111;

  localparam logic [6:0] F7_ALT  = 7'b0100000;

  localparam logic [4:0] REG_ZERO = 5'd0;
  localparam logic [4:0] REG_RA   = 5'd1;
  localparam logic [4:0] REG_SP   = 5'd2;

  // Result of one quadrant decoder
  typedef struct packed {
    logic [31:0] word;
    logic        bad;
  } xlat_t;

  // Short register field: x8..x15
  function automatic logic [4:0] prime_reg(input logic [2:0] p);
    return {2'b01, p};
  endfunction

  function automatic logic [31:0] fmt_i(input logic [11:0] imm, input logic [4:0] rs1,
                                        input logic [2:0] f3, input logic [4:0] rd,
                                        input logic [6:0] op);
    return {imm, rs1, f3, rd, op};
  endfunction

  function automatic logic [31:0] fmt_s(input logic [11:0] imm, input logic [4:0] rs2,
                                        input logic [4:0] rs1, input logic [2:0] f3,
                                        input logic [6:0] op);
    return {imm[11:5], rs2, rs1, f3, imm[4:0], op};
  endfunction

  function automatic logic [31:0] fmt_r(input logic [6:0] f7, input logic [4:0] rs2,
                                        input logic [4:0] rs1, input logic [2:0] f3,
                                        input logic [4:0] rd, input logic [6:0] op);
    return {f7, rs2, rs1, f3, rd, op};
  endfunction

  function automatic logic [31:0] fmt_b(input logic [12:0] imm, input logic [4:0] rs1,
                                        input logic [2:0] f3);
    return {imm[12], imm[10:5], REG_ZERO, rs1, f3, imm[4:1], imm[11], OPC_BRANCH};
  endfunction

  function automatic logic [31:0] fmt_j(input logic [20:0] imm, input logic [4:0] rd);
    return {imm[20], imm[10:1], imm[11], imm[19:12], rd, OPC_JAL};
  endfunction

  function automatic logic [31:0] fmt_u(input logic [19:0] imm, input logic [4:0] rd);
    return {imm, rd, OPC_LUI};
  endfunction

endpackage

// File: rtl/rvc_q0_dec.sv
module rvc_q0_dec
  import rvc_pkg::*;
#(
  parameter bit WIDE = 1'b0
) (
  input  logic [15:2] c,
  output xlat_t       res
);

  logic [4:0]  rs1p;
  logic [4:0]  rdp;
  logic [9:0]  spn_imm;
  logic [11:0] w_off;
  logic [11:0] d_off;

  assign rs1p    = prime_reg(c[9:7]);
  assign rdp     = prime_reg(c[4:2]);
  assign spn_imm = {c[10:7], c[12:11], c[5], c[6], 2'b00};
  assign w_off   = {5'b0, c[5], c[12:10], c[6], 2'b00};
  assign d_off   = {4'b0, c[6:5], c[12:10], 3'b000};

  always_comb begin
    res.word = '0;
    res.bad  = 1'b0;
    unique case (c[15:13])
      3'b000: begin
        res.word = fmt_i({2'b00, spn_imm}, REG_SP, F3_ADD, rdp, OPC_OP_IMM);
        res.bad  = (spn_imm == '0);
      end
      3'b001: res.word = fmt_i(d_off, rs1p, F3_DBL, rdp, OPC_LOAD_FP);
      3'b010: res.word = fmt_i(w_off, rs1p, F3_WORD, rdp, OPC_LOAD);
      3'b011: res.word = WIDE ? fmt_i(d_off, rs1p, F3_DBL, rdp, OPC_LOAD)
                              : fmt_i(w_off, rs1p, F3_WORD, rdp, OPC_LOAD_FP);
      3'b100: res.bad  = 1'b1;
      3'b101: res.word = fmt_s(d_off, rdp, rs1p, F3_DBL, OPC_STORE_FP);
      3'b110: res.word = fmt_s(w_off, rdp, rs1p, F3_WORD, OPC_STORE);
      3'b111: res.word = WIDE ? fmt_s(d_off, rdp, rs1p, F3_DBL, OPC_STORE)
                              : fmt_s(w_off, rdp, rs1p, F3_WORD, OPC_STORE_FP);
      default: res.bad = 1'b1;
    endcase
  end

endmodule

// File: rtl/rvc_q1_dec.sv
module rvc_q1_dec
  import rvc_pkg::*;
#(
  parameter bit WIDE = 1'b0
) (
  input  logic [15:2] c,
  output xlat_t       res
);

  logic [4:0]  rd;
  logic [4:0]  rdp;
  logic [4:0]  rs2p;
  logic [5:0]  imm6;
  logic [11:0] imm6_sx;
  logic [11:0] jmp_raw;
  logic [20:0] jmp_sx;
  logic [8:0]  br_raw;
  logic [12:0] br_sx;
  logic [9:0]  sp16;
  logic [11:0] sp16_sx;
  logic [19:0] lui_sx;
  logic [11:0] shift_imm;

  assign rd        = c[11:7];
  assign rdp       = prime_reg(c[9:7]);
  assign rs2p      = prime_reg(c[4:2]);
  assign imm6      = {c[12], c[6:2]};
  assign imm6_sx   = {{6{imm6[5]}}, imm6};
  assign jmp_raw   = {c[12], c[8], c[10:9], c[6], c[7], c[2], c[11], c[5:3], 1'b0};
  assign jmp_sx    = {{9{jmp_raw[11]}}, jmp_raw};
  assign br_raw    = {c[12], c[6:5], c[2], c[11:10], c[4:3], 1'b0};
  assign br_sx     = {{4{br_raw[8]}}, br_raw};
  assign sp16      = {c[12], c[4:3], c[5], c[2], c[6], 4'b0000};
  assign sp16_sx   = {{2{sp16[9]}}, sp16};
  assign lui_sx    = {{14{imm6[5]}}, imm6};
  // srai carries the alternate bit; shift amount spans six bits
  assign shift_imm = {1'b0, c[10], 4'b0000, c[12], c[6:2]};

  always_comb begin
    res.word = '0;
    res.bad  = 1'b0;
    unique case (c[15:13])
      3'b000: res.word = fmt_i(imm6_sx, rd, F3_ADD, rd, OPC_OP_IMM);
      3'b001: begin
        if (WIDE) begin
          res.word = fmt_i(imm6_sx, rd, F3_ADD, rd, OPC_OP_IMM32);
          res.bad  = (rd == REG_ZERO);
        end else begin
          res.word = fmt_j(jmp_sx, REG_RA);
        end
      end
      3'b010: begin
        res.word = fmt_i(imm6_sx, REG_ZERO, F3_ADD, rd, OPC_OP_IMM);
        res.bad  = (rd == REG_ZERO);
      end
      3'b011: begin
        if (rd == REG_SP) begin
          res.word = fmt_i(sp16_sx, REG_SP, F3_ADD, REG_SP, OPC_OP_IMM);
          res.bad  = (sp16 == '0);
        end else begin
          res.word = fmt_u(lui_sx, rd);
          res.bad  = (imm6 == '0);
        end
      end
      3'b100: begin
        unique case (c[11:10])
          2'b00, 2'b01: begin
            res.word = fmt_i(shift_imm, rdp, F3_SR, rdp, OPC_OP_IMM);
            res.bad  = !WIDE && c[12];
          end
          2'b10: res.word = fmt_i(imm6_sx, rdp, F3_AND, rdp, OPC_OP_IMM);
          default: begin
            if (!c[12]) begin
              unique case (c[6:5])
                2'b00:   res.word = fmt_r(F7_ALT, rs2p, rdp, F3_ADD, rdp, OPC_OP);
                2'b01:   res.word = fmt_r(7'b0, rs2p, rdp, F3_XOR, rdp, OPC_OP);
                2'b10:   res.word = fmt_r(7'b0, rs2p, rdp, F3_OR, rdp, OPC_OP);
                default: res.word = fmt_r(7'b0, rs2p, rdp, F3_AND, rdp, OPC_OP);
              endcase
            end else begin
              res.word = fmt_r(c[5] ? 7'b0 : F7_ALT, rs2p, rdp, F3_ADD, rdp, OPC_OP32);
              res.bad  = !WIDE || c[6];
            end
          end
        endcase
      end
      3'b101: res.word = fmt_j(jmp_sx, REG_ZERO);
      3'b110: res.word = fmt_b(br_sx, rdp, F3_ADD);
      3'b111: res.word = fmt_b(br_sx, rdp, F3_SLL);
      default: res.bad = 1'b1;
    endcase
  end

endmodule

// File: rtl/rvc_q2_dec.sv
module rvc_q2_dec
  import rvc_pkg::*;
#(
  parameter bit WIDE = 1'b0
) (
  input  logic [15:2] c,
  output xlat_t       res
);

  logic [4:0]  rd;
  logic [4:0]  rs2;
  logic [11:0] ld_w;
  logic [11:0] ld_d;
  logic [11:0] st_w;
  logic [11:0] st_d;
  logic [11:0] sh_imm;

  assign rd     = c[11:7];
  assign rs2    = c[6:2];
  assign ld_w   = {4'b0, c[3:2], c[12], c[6:4], 2'b00};
  assign ld_d   = {3'b0, c[4:2], c[12], c[6:5], 3'b000};
  assign st_w   = {4'b0, c[8:7], c[12:9], 2'b00};
  assign st_d   = {3'b0, c[9:7], c[12:10], 3'b000};
  assign sh_imm = {6'b0, c[12], c[6:2]};

  always_comb begin
    res.word = '0;
    res.bad  = 1'b0;
    unique case (c[15:13])
      3'b000: begin
        res.word = fmt_i(sh_imm, rd, F3_SLL, rd, OPC_OP_IMM);
        res.bad  = !WIDE && c[12];
      end
      3'b001: res.word = fmt_i(ld_d, REG_SP, F3_DBL, rd, OPC_LOAD_FP);
      3'b010: begin
        res.word = fmt_i(ld_w, REG_SP, F3_WORD, rd, OPC_LOAD);
        res.bad  = (rd == REG_ZERO);
      end
      3'b011: begin
        if (WIDE) begin
          res.word = fmt_i(ld_d, REG_SP, F3_DBL, rd, OPC_LOAD);
          res.bad  = (rd == REG_ZERO);
        end else begin
          res.word = fmt_i(ld_w, REG_SP, F3_WORD, rd, OPC_LOAD_FP);
        end
      end
      3'b100: begin
        if (!c[12]) begin
          if (rs2 == REG_ZERO) begin
            res.word = fmt_i(12'd0, rd, F3_ADD, REG_ZERO, OPC_JALR);
            res.bad  = (rd == REG_ZERO);
          end else begin
            res.word = fmt_r(7'b0, rs2, REG_ZERO, F3_ADD, rd, OPC_OP);
          end
        end else if (rs2 == REG_ZERO) begin
          res.word = (rd == REG_ZERO) ? WORD_EBREAK
                                      : fmt_i(12'd0, rd, F3_ADD, REG_RA, OPC_JALR);
        end else begin
          res.word = fmt_r(7'b0, rs2, rd, F3_ADD, rd, OPC_OP);
        end
      end
      3'b101: res.word = fmt_s(st_d, rs2, REG_SP, F3_DBL, OPC_STORE_FP);
      3'b110: res.word = fmt_s(st_w, rs2, REG_SP, F3_WORD, OPC_STORE);
      3'b111: res.word = WIDE ? fmt_s(st_d, rs2, REG_SP, F3_DBL, OPC_STORE)
                              : fmt_s(st_w, rs2, REG_SP, F3_WORD, OPC_STORE_FP);
      default: res.bad = 1'b1;
    endcase
  end

endmodule

// File: rtl/rvc_expander.sv
module rvc_expander
  import rvc_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [31:0] in_word,
  output logic [31:0] out_word,
  output logic        out_illegal,
  output logic        out_compressed
);

  localparam bit WIDE    = (XLEN == 64);
  localparam int NQUAD   = 3;

  xlat_t quad_res [NQUAD];

  generate
    for (genvar q = 0; q < NQUAD; q++) begin : g_quad
      if (q == 0) begin : g_q0
        rvc_q0_dec #(.WIDE(WIDE)) u_dec (.c(in_word[15:2]), .res(quad_res[q]));
      end else if (q == 1) begin : g_q1
        rvc_q1_dec #(.WIDE(WIDE)) u_dec (.c(in_word[15:2]), .res(quad_res[q]));
      end else begin : g_q2
        rvc_q2_dec #(.WIDE(WIDE)) u_dec (.c(in_word[15:2]), .res(quad_res[q]));
      end
    end
  endgenerate

  xlat_t sel;

  always_comb begin
    unique case (in_word[1:0])
      2'b00:   sel = quad_res[0];
      2'b01:   sel = quad_res[1];
      2'b10:   sel = quad_res[2];
      default: sel = '{word: in_word, bad: 1'b0};
    endcase
  end

  assign out_compressed = (in_word[1:0] != 2'b11);
  assign out_illegal    = sel.bad;
  assign out_word       = sel.bad ? {16'h0000, in_word[15:0]} : sel.word;

endmodule

// File: rtl/rvc_expander_checker.sv
module rvc_expander_checker #(
  parameter int unsigned XLEN = 32
) (
  input logic [31:0] in_word,
  input logic [31:0] out_word,
  input logic        out_illegal,
  input logic        out_compressed
);

  localparam bit WIDE = (XLEN == 64);

  logic q1_shift;
  logic q2_shift;
  assign q1_shift = (in_word[1:0] == 2'b01) && (in_word[15:13] == 3'b100) && !in_word[11];
  assign q2_shift = (in_word[1:0] == 2'b10) && (in_word[15:13] == 3'b000);

  always_comb begin
    assert_passthru_R1: assert (out_compressed || (out_word == in_word && !out_illegal));
    assert_illegal_zext_R12: assert (!out_illegal || out_word == {16'h0000, in_word[15:0]});
    assert_zero_half_R12: assert (!(in_word[15:0] == 16'h0000) || out_illegal);
    assert_full_len_R12: assert (out_illegal || out_word[1:0] == 2'b11);
    assert_ebreak_R11: assert (!(in_word[15:0] == 16'h9002) || out_word == 32'h0010_0073);
    assert_shamt32_R8: assert (WIDE || !(q1_shift && in_word[12]) || out_illegal);
    assert_shamt32_R10: assert (WIDE || !(q2_shift && in_word[12]) || out_illegal);
  end

endmodule

bind rvc_expander rvc_expander_checker #(.XLEN(XLEN)) u_chk (
  .in_word(in_word),
  .out_word(out_word),
  .out_illegal(out_illegal),
  .out_compressed(out_compressed)
);

// File: tb/rvc_expander_bench.sv
`timescale 1ns/1ps
module rvc_expander_bench;

  localparam logic [6:0] LD  = 7'b0000011, LDF = 7'b0000111, OPI = 7'b0010011,
                         OPIW = 7'b0011011, ST = 7'b0100011, STF = 7'b0100111,
                         OPR = 7'b0110011, OPW = 7'b0111011, JR = 7'b1100111;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [31:0] stim = 32'h0;
  logic [31:0] w32, w64;
  logic        i32, i64, c32, c64;

  rvc_expander #(.XLEN(32)) u_rvc_expander (
    .in_word(stim), .out_word(w32), .out_illegal(i32), .out_compressed(c32));
  rvc_expander #(.XLEN(64)) u_rvc_expander_w64 (
    .in_word(stim), .out_word(w64), .out_illegal(i64), .out_compressed(c64));

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  // Reference 32-bit formats
  function automatic logic [31:0] e_i(int imm, int rs1, int f3, int rd, logic [6:0] op);
    logic [31:0] t = imm;
    return {t[11:0], 5'(rs1), 3'(f3), 5'(rd), op};
  endfunction
  function automatic logic [31:0] e_s(int imm, int rs2, int rs1, int f3, logic [6:0] op);
    logic [31:0] t = imm;
    return {t[11:5], 5'(rs2), 5'(rs1), 3'(f3), t[4:0], op};
  endfunction
  function automatic logic [31:0] e_r(int f7, int rs2, int rs1, int f3, int rd, logic [6:0] op);
    return {7'(f7), 5'(rs2), 5'(rs1), 3'(f3), 5'(rd), op};
  endfunction
  function automatic logic [31:0] e_b(int imm, int rs1, int f3);
    logic [31:0] t = imm;
    return {t[12], t[10:5], 5'd0, 5'(rs1), 3'(f3), t[4:1], t[11], 7'b1100011};
  endfunction
  function automatic logic [31:0] e_j(int imm, int rd);
    logic [31:0] t = imm;
    return {t[20], t[10:1], t[11], t[19:12], 5'(rd), 7'b1101111};
  endfunction

  task automatic chk(input string req, input bit wide, input logic [31:0] w,
                     input logic [31:0] exp_w, input bit exp_ill);
    logic [31:0] ow;
    logic        oi, oc, exp_c;
    @(posedge clk);
    stim <= w;
    @(negedge clk);
    ow = wide ? w64 : w32;
    oi = wide ? i64 : i32;
    oc = wide ? c64 : c32;
    exp_c = (w[1:0] != 2'b11);
    n_chk++;
    if (ow !== exp_w || oi !== exp_ill || oc !== exp_c) begin
      n_bad++;
      $display("FAIL %s xlen%0d in=%h: word=%h ill=%b cmp=%b expected word=%h ill=%b cmp=%b",
               req, wide ? 64 : 32, w, ow, oi, oc, exp_w, exp_ill, exp_c);
    end
  endtask

  task automatic chk_bad(input string req, input bit wide, input logic [31:0] w);
    chk(req, wide, w, {16'h0, w[15:0]}, 1'b1);
  endtask

  task automatic t_passthru;
    chk("R1", 0, 32'hDEADBEEF, 32'hDEADBEEF, 0);
    chk("R1", 1, 32'h00A50533, 32'h00A50533, 0);
    chk("R1", 0, {16'hFFFF, 16'h0001}, 32'h00000013, 0);
    chk("R4", 1, 32'h0000_0001, 32'h00000013, 0);
  endtask

  task automatic t_q0;
    chk("R2", 0, {3'b000, 8'hFF, 3'b001, 2'b00}, e_i(1020, 2, 0, 9, OPI), 0);
    chk("R2", 1, {3'b000, 8'b00000010, 3'b010, 2'b00}, e_i(4, 2, 0, 10, OPI), 0);
    chk("R3", 0, {3'b010, 3'b111, 3'b010, 2'b11, 3'b011, 2'b00}, e_i(124, 10, 2, 11, LD), 0);
    chk("R3", 0, {3'b110, 3'b000, 3'b111, 2'b01, 3'b000, 2'b00}, e_s(64, 8, 15, 2, ST), 0);
    chk("R3", 1, {3'b011, 3'b111, 3'b001, 2'b11, 3'b101, 2'b00}, e_i(248, 9, 3, 13, LD), 0);
    chk("R3", 0, {3'b011, 3'b111, 3'b001, 2'b11, 3'b101, 2'b00}, e_i(124, 9, 2, 13, LDF), 0);
    chk("R3", 1, {3'b101, 3'b001, 3'b100, 2'b00, 3'b010, 2'b00}, e_s(8, 10, 12, 3, STF), 0);
    chk("R3", 1, {3'b111, 3'b000, 3'b011, 2'b11, 3'b110, 2'b00}, e_s(192, 14, 11, 3, ST), 0);
    chk("R3", 0, {3'b111, 3'b000, 3'b011, 2'b11, 3'b110, 2'b00}, e_s(68, 14, 11, 2, STF), 0);
    chk("R3", 0, {3'b001, 3'b000, 3'b000, 2'b00, 3'b000, 2'b00}, e_i(0, 8, 3, 8, LDF), 0);
  endtask

  task automatic t_q1_imm;
    chk("R4", 0, {3'b000, 1'b1, 5'd5, 5'b00000, 2'b01}, e_i(-32, 5, 0, 5, OPI), 0);
    chk("R4", 0, {3'b000, 1'b0, 5'd5, 5'b11111, 2'b01}, e_i(31, 5, 0, 5, OPI), 0);
    chk("R4", 0, {3'b010, 1'b1, 5'd10, 5'b11111, 2'b01}, e_i(-1, 0, 0, 10, OPI), 0);
    chk("R4", 1, {3'b001, 1'b0, 5'd31, 5'b11111, 2'b01}, e_i(31, 31, 0, 31, OPIW), 0);
  endtask

  task automatic t_jumps;
    chk("R5", 0, {3'b001, 1'b1, 10'b0, 2'b01}, e_j(-2048, 1), 0);
    chk("R5", 0, {3'b001, 1'b0, 10'h3FF, 2'b01}, e_j(2046, 1), 0);
    chk("R5", 1, {3'b101, 1'b0, 10'h3FF, 2'b01}, e_j(2046, 0), 0);
    chk("R5", 0, {3'b101, 1'b1, 10'h3FF, 2'b01}, e_j(-2, 0), 0);
  endtask

  task automatic t_branch;
    chk("R6", 0, {3'b110, 1'b1, 2'b00, 3'b000, 5'b00000, 2'b01}, e_b(-256, 8, 0), 0);
    chk("R6", 1, {3'b111, 1'b0, 2'b11, 3'b111, 5'b11111, 2'b01}, e_b(254, 15, 1), 0);
  endtask

  task automatic t_sp_lui;
    chk("R7", 0, {3'b011, 1'b1, 5'd2, 5'b00000, 2'b01}, e_i(-512, 2, 0, 2, OPI), 0);
    chk("R7", 1, {3'b011, 1'b0, 5'd2, 5'b11111, 2'b01}, e_i(496, 2, 0, 2, OPI), 0);
    chk("R7", 0, {3'b011, 1'b1, 5'd3, 5'b11111, 2'b01}, 32'hFFFFF1B7, 0);
    chk("R7", 1, {3'b011, 1'b0, 5'd3, 5'b00001, 2'b01}, 32'h000011B7, 0);
  endtask

  task automatic t_alu;
    chk("R8", 0, {3'b100, 1'b0, 2'b00, 3'b001, 5'd3, 2'b01}, e_i(3, 9, 5, 9, OPI), 0);
    chk("R8", 0, {3'b100, 1'b0, 2'b01, 3'b010, 5'd31, 2'b01}, e_i(12'h41F, 10, 5, 10, OPI), 0);
    chk("R8", 1, {3'b100, 1'b1, 2'b01, 3'b010, 5'd1, 2'b01}, e_i(12'h421, 10, 5, 10, OPI), 0);
    chk_bad("R8", 0, {3'b100, 1'b1, 2'b01, 3'b010, 5'd1, 2'b01});
    chk("R8", 0, {3'b100, 1'b1, 2'b10, 3'b011, 5'd0, 2'b01}, e_i(-32, 11, 7, 11, OPI), 0);
    chk("R9", 0, {6'b100011, 3'b000, 2'b00, 3'b001, 2'b01}, e_r(32, 9, 8, 0, 8, OPR), 0);
    chk("R9", 0, {6'b100011, 3'b100, 2'b01, 3'b101, 2'b01}, e_r(0, 13, 12, 4, 12, OPR), 0);
    chk("R9", 1, {6'b100011, 3'b110, 2'b10, 3'b111, 2'b01}, e_r(0, 15, 14, 6, 14, OPR), 0);
    chk("R9", 0, {6'b100011, 3'b111, 2'b11, 3'b000, 2'b01}, e_r(0, 8, 15, 7, 15, OPR), 0);
    chk("R9", 1, {6'b100111, 3'b001, 2'b00, 3'b010, 2'b01}, e_r(32, 10, 9, 0, 9, OPW), 0);
    chk("R9", 1, {6'b100111, 3'b000, 2'b01, 3'b000, 2'b01}, e_r(0, 8, 8, 0, 8, OPW), 0);
    chk_bad("R9", 0, {6'b100111, 3'b001, 2'b00, 3'b010, 2'b01});
    chk_bad("R9", 1, {6'b100111, 3'b001, 2'b10, 3'b010, 2'b01});
  endtask

  task automatic t_q2_sp;
    chk("R10", 0, {3'b000, 1'b0, 5'd1, 5'd1, 2'b10}, e_i(1, 1, 1, 1, OPI), 0);
    chk("R10", 1, {3'b000, 1'b1, 5'd1, 5'd0, 2'b10}, e_i(32, 1, 1, 1, OPI), 0);
    chk_bad("R10", 0, {3'b000, 1'b1, 5'd1, 5'd0, 2'b10});
    chk("R10", 0, {3'b010, 1'b1, 5'd5, 5'b11111, 2'b10}, e_i(252, 2, 2, 5, LD), 0);
    chk("R10", 1, {3'b011, 1'b1, 5'd6, 5'b11111, 2'b10}, e_i(504, 2, 3, 6, LD), 0);
    chk("R10", 0, {3'b011, 1'b1, 5'd6, 5'b11111, 2'b10}, e_i(252, 2, 2, 6, LDF), 0);
    chk("R10", 0, {3'b001, 1'b0, 5'd0, 5'b01000, 2'b10}, e_i(8, 2, 3, 0, LDF), 0);
    chk("R10", 0, {3'b110, 6'b111111, 5'd31, 2'b10}, e_s(252, 31, 2, 2, ST), 0);
    chk("R10", 1, {3'b111, 6'b111111, 5'd1, 2'b10}, e_s(504, 1, 2, 3, ST), 0);
    chk("R10", 0, {3'b111, 6'b111111, 5'd1, 2'b10}, e_s(252, 1, 2, 2, STF), 0);
    chk("R10", 1, {3'b101, 6'b000001, 5'd2, 2'b10}, e_s(64, 2, 2, 3, STF), 0);
  endtask

  task automatic t_q2_misc;
    chk("R11", 0, {3'b100, 1'b0, 5'd1, 5'd0, 2'b10}, 32'h00008067, 0);
    chk("R11", 1, {3'b100, 1'b0, 5'd10, 5'd11, 2'b10}, e_r(0, 11, 0, 0, 10, OPR), 0);
    chk("R11", 0, 32'h0000_9002, 32'h00100073, 0);
    chk("R11", 1, {3'b100, 1'b1, 5'd5, 5'd0, 2'b10}, e_i(0, 5, 0, 1, JR), 0);
    chk("R11", 0, {3'b100, 1'b1, 5'd10, 5'd11, 2'b10}, e_r(0, 11, 10, 0, 10, OPR), 0);
  endtask

  task automatic t_illegal;
    chk_bad("R12", 0, 32'h0000_0000);
    chk_bad("R12", 1, {16'hABCD, 16'h0004});
    chk_bad("R12", 0, {3'b100, 13'h0});
    chk_bad("R12", 0, {3'b010, 1'b0, 5'd0, 5'd1, 2'b01});
    chk_bad("R12", 1, {3'b001, 1'b1, 5'd0, 5'd0, 2'b01});
    chk_bad("R12", 0, {3'b011, 1'b0, 5'd2, 5'd0, 2'b01});
    chk_bad("R12", 1, {3'b011, 1'b0, 5'd3, 5'd0, 2'b01});
    chk_bad("R12", 0, {3'b010, 1'b0, 5'd0, 5'd0, 2'b10});
    chk_bad("R12", 1, {3'b011, 1'b1, 5'd0, 5'd0, 2'b10});
    chk_bad("R12", 0, 32'h0000_8002);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (2) @(posedge clk);
    t_passthru();
    t_q0();
    t_q1_imm();
    t_jumps();
    t_branch();
    t_sp_lui();
    t_alu();
    t_q2_sp();
    t_q2_misc();
    t_illegal();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      summary();
      $finish;
    end
  end

endmodule